// File: doc/BRIEF.md
# AES-128 Decryption Key Preparation Engine

This block turns a 128-bit AES encryption key into the key that starts an ECB or CBC decryption. That key is the last round key of the forward key schedule. Software loads the encryption key into four word registers while the engine is idle. It then selects the key-preparation mode and sets the run bit. The engine steps through the ten rounds of the schedule, one round per clock. It then writes the result back over the key registers, raises a done flag and clears the run bit in hardware. Software can read the prepared key back, or leave it where it is for a later decrypt-only pass.

The register file also holds a chaining-mode field and four IV words. The chaining mode has no effect on key preparation, and the IV words are write-protected while key preparation is selected. The decrypt-only mode value is decoded and brought out as a ready indication. The cipher datapaths themselves lie outside this block.

Top module: `aeskd_engine`

## Requirements
- R1: After a synchronous reset, the control word (offset 0) and the status word (offset 1) read as zero, and every key word reads as zero.
- R2: The mode field is control bits [2:1], and value 01 selects key preparation. Setting control bit 0 (run) with this mode replaces the key words with the tenth round key of the AES-128 schedule. Key word offset 2 holds key bits [127:96], and offset 5 holds bits [31:0]. The key 2b7e151628aed2a6abf7158809cf4f3c gives d014f9a8c9ee2589e13f0cc8b6630ca6.
- R3: On completion, status bit 0 and the `kd_done` output become 1 and stay 1 until software clears them.
- R4: On completion, hardware clears the run bit, and the mode field keeps its value.
- R5: The chaining field is control bits [4:3]. Its value does not change the prepared key.
- R6: IV words (offsets 6 to 9) ignore writes while the mode field holds 01, and accept writes under any other mode.
- R7: Key words ignore writes while the run bit is 1.
- R8: Writing a control word with bit 8 set clears the done flag.
- R9: `kd_done` reads 1 exactly 11 clock cycles after the clock edge that sets the run bit in key-preparation mode.
- R10: A second preparation with a new key needs no reset and gives the schedule result for the new key. The all-zero key gives b4ef5bcb3e92e21123e951cf6f8f188e.
- R11: Mode 10 with run set drives `dec_ready` high and starts no key preparation. The done flag stays 0 and the key words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| kd_done | output | 1 | Key preparation complete flag |
| dec_ready | output | 1 | Decrypt-only mode selected and running |

## Verification
The assertions assume that software changes the key only through the word registers and never expects a control write to take effect while a preparation is running. They also assume that the mode field is the only thing that guards the IV words. The stimulus changes mode and run only between preparations. It polls the done flag before it touches the key words, and it sets the clear bit only when the engine is idle. Expected keys come from published schedule values, so they do not depend on the design's arithmetic.

// File: rtl/aeskd_pkg.sv
package aeskd_pkg;

    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 4;
    localparam int ROUNDS    = 10;
    localparam int CNT_W     = $clog2(ROUNDS);
    localparam int ADDR_W    = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_IV   = 4'd6;
    localparam int CLR_BIT = 8;

    typedef logic [KEY_WORDS-1:0][WORD_W-1:0] key_t;

    typedef enum logic [1:0] {
        MODE_CIPHER  = 2'b00,
        MODE_KEYPREP = 2'b01,
        MODE_DECRYPT = 2'b10,
        MODE_COMBO   = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] chain;
        mode_e      mode;
        logic       run;
    } ctrl_t;

    typedef enum logic {PH_IDLE = 1'b0, PH_ROUND = 1'b1} phase_e;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254, then the affine map
    function automatic logic [7:0] sbox_calc(input logic [7:0] a);
        logic [7:0] sq  = a;
        logic [7:0] inv = 8'h01;
        logic [7:0] r;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        r = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        return r;
    endfunction

endpackage

// File: rtl/aeskd_sbox.sv
module aeskd_sbox
    import aeskd_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    assign dout = sbox_calc(din);
endmodule

// File: rtl/aeskd_round.sv
module aeskd_round
    import aeskd_pkg::*;
(
    input  key_t       cur,
    input  logic [7:0] rcon,
    output key_t       nxt
);
    logic [WORD_W-1:0] rot;
    logic [WORD_W-1:0] sub;
    logic [WORD_W-1:0] mix;

    // word index KEY_WORDS-1 is the most significant (first) word
    assign rot = {cur[0][23:0], cur[0][31:24]};

    for (genvar b = 0; b < 4; b++) begin : g_sub
        aeskd_sbox u_sbox (.din(rot[8*b +: 8]), .dout(sub[8*b +: 8]));
    end

    assign mix = sub ^ {rcon, 24'h000000};

    assign nxt[KEY_WORDS-1] = cur[KEY_WORDS-1] ^ mix;
    for (genvar w = KEY_WORDS-2; w >= 0; w--) begin : g_chain
        assign nxt[w] = cur[w] ^ nxt[w+1];
    end
endmodule

// File: rtl/aeskd_sched.sv
module aeskd_sched
    import aeskd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  key_t key_in,
    output logic busy,
    output logic finish,
    output key_t key_out
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    phase_e           phase;
    logic [CNT_W-1:0] rnd;
    logic [7:0]       rcon;
    key_t             work;
    key_t             nxt;

    aeskd_round u_round (.cur(work), .rcon(rcon), .nxt(nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            rnd   <= '0;
            rcon  <= 8'h01;
            work  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    work  <= key_in;
                    rnd   <= '0;
                    rcon  <= 8'h01;
                    phase <= PH_ROUND;
                end
                PH_ROUND: begin
                    work <= nxt;
                    rcon <= xtime(rcon);
                    rnd  <= rnd + 1'b1;
                    if (rnd == LAST) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (phase == PH_ROUND);
    assign finish  = busy && (rnd == LAST);
    assign key_out = nxt;

    // R9
    rnd_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rnd <= LAST));
    // R9
    first_rcon_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && rcon == 8'h01 && rnd == '0));
    // R4
    finish_idle_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> !busy);
endmodule

// File: rtl/aeskd_engine.sv
module aeskd_engine
    import aeskd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              kd_done,
    output logic              dec_ready
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t ctrl_q;
    logic  done_q;
    key_t  key_q;
    key_t  iv_q;
    key_t  key_new;
    logic  busy, finish, start;
    logic  ctrl_wr;

    assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
    assign start   = ctrl_q.run && (ctrl_q.mode == MODE_KEYPREP) && !busy;

    aeskd_sched u_sched (
        .clk(clk), .rst(rst), .start(start), .key_in(key_q),
        .busy(busy), .finish(finish), .key_out(key_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (finish) begin
            ctrl_q.run <= 1'b0;
        end else if (ctrl_wr && !busy) begin
            ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               done_q <= 1'b0;
        else if (finish)                       done_q <= 1'b1;
        else if (ctrl_wr && reg_wdata[CLR_BIT]) done_q <= 1'b0;
    end

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_words
        localparam logic [ADDR_W-1:0] KA = OFS_KEY + ADDR_W'(i);
        localparam logic [ADDR_W-1:0] IA = OFS_IV + ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (rst)
                key_q[KEY_WORDS-1-i] <= '0;
            else if (finish)
                key_q[KEY_WORDS-1-i] <= key_new[KEY_WORDS-1-i];
            else if (reg_we && reg_addr == KA && !ctrl_q.run)
                key_q[KEY_WORDS-1-i] <= reg_wdata;
        end
        always_ff @(posedge clk) begin
            if (rst)
                iv_q[KEY_WORDS-1-i] <= '0;
            else if (reg_we && reg_addr == IA && ctrl_q.mode != MODE_KEYPREP)
                iv_q[KEY_WORDS-1-i] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CTRL)
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        else if (reg_addr == OFS_STAT)
            reg_rdata[0] = done_q;
        else if (reg_addr >= OFS_KEY && reg_addr < OFS_KEY + ADDR_W'(KEY_WORDS))
            reg_rdata = key_q[KEY_WORDS-1-int'(reg_addr - OFS_KEY)];
        else if (reg_addr >= OFS_IV && reg_addr < OFS_IV + ADDR_W'(KEY_WORDS))
            reg_rdata = iv_q[KEY_WORDS-1-int'(reg_addr - OFS_IV)];
    end

    assign kd_done   = done_q;
    assign dec_ready = ctrl_q.run && (ctrl_q.mode == MODE_DECRYPT);

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:CLR_BIT+1], reg_wdata[CLR_BIT-1:CTRL_W]};

    // R4
    run_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> !ctrl_q.run);
    // R3
    done_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(busy));
    // R7
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl_q.run) && ctrl_q.run) |-> $stable(key_q));
    // R6
    iv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl_q.mode) == MODE_KEYPREP) |-> $stable(iv_q));
    // R11
    no_prep_chk: assert property (@(posedge clk) disable iff (rst)
        dec_ready |-> !busy);
endmodule

// File: tb/aeskd_engine_test.sv
module aeskd_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        kd_done, dec_ready;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [127:0] exp_q[$];
    logic [127:0] obs_q[$];
    string        tag_q[$];

    localparam logic [127:0] NIST_KEY  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] NIST_LAST = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    localparam logic [127:0] ZERO_LAST = 128'hb4ef5bcb3e92e21123e951cf6f8f188e;

    aeskd_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .kd_done(kd_done), .dec_ready(dec_ready)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_key(input logic [127:0] k);
        for (int i = 0; i < 4; i++) wr(4'(2 + i), k[127 - 32*i -: 32]);
    endtask

    task automatic read_key(output logic [127:0] k);
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            rd(4'(2 + i), w);
            k[127 - 32*i -: 32] = w;
        end
    endtask

    // driver: pushes the expected key, runs one preparation, collects the result
    task automatic prepare(input string req, input logic [127:0] key,
                           input logic [127:0] expect_key, input logic [1:0] chain);
        logic [127:0] got;
        int n;
        exp_q.push_back(expect_key);
        tag_q.push_back(req);
        load_key(key);
        wr(4'd0, {27'd0, chain, 2'b01, 1'b1});
        n = 0;
        while (!kd_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R9 latency", 32'(n), 32'd11);
        read_key(got);
        obs_q.push_back(got);
    endtask

    // monitor: compares results against the scoreboard queue
    always @(negedge clk) begin
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            logic [127:0] o, e;
            string t;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (o !== e) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, o, e);
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 32'd0);
        rd(4'd1, v); chk("R1 status", v, 32'd0);
        rd(4'd3, v); chk("R1 key", v, 32'd0);

        // R6 IV write ignored under key preparation mode
        wr(4'd0, 32'h2);
        wr(4'd6, 32'hdeadbeef);
        rd(4'd6, v); chk("R6 iv blocked", v, 32'd0);

        // R2 main vector
        prepare("R2 nist", NIST_KEY, NIST_LAST, 2'b00);
        chk("R3 done pin", 32'(kd_done), 32'd1);
        rd(4'd1, v); chk("R3 status", v, 32'd1);
        rd(4'd0, v); chk("R4 run cleared", v, 32'h2);
        @(negedge clk);
        chk("R3 done held", 32'(kd_done), 32'd1);

        // R8 clear
        wr(4'd0, 32'h102);
        chk("R8 done cleared", 32'(kd_done), 32'd0);
        rd(4'd1, v); chk("R8 status", v, 32'd0);

        // R5 chaining field ignored
        prepare("R5 chain3", NIST_KEY, NIST_LAST, 2'b11);
        wr(4'd0, 32'h100);
        prepare("R5 chain2", NIST_KEY, NIST_LAST, 2'b10);
        wr(4'd0, 32'h100);

        // R10 rerun with another key, no reset
        prepare("R10 zero key", 128'd0, ZERO_LAST, 2'b01);
        wr(4'd0, 32'h100);

        // R6 IV accepted outside key preparation mode
        wr(4'd7, 32'h12345678);
        rd(4'd7, v); chk("R6 iv accepted", v, 32'h12345678);

        // R11 / R7 decrypt-only mode
        wr(4'd0, 32'h5);
        @(negedge clk);
        chk("R11 dec_ready", 32'(dec_ready), 32'd1);
        wr(4'd2, 32'hffffffff);
        rd(4'd2, v); chk("R7 key write ignored", v, ZERO_LAST[127:96]);
        repeat (20) @(negedge clk);
        chk("R11 no done", 32'(kd_done), 32'd0);
        rd(4'd5, v); chk("R11 key unchanged", v, ZERO_LAST[31:0]);
        wr(4'd0, 32'h0);
        chk("R11 dec_ready low", 32'(dec_ready), 32'd0);

        repeat (3) @(negedge clk);
        chk("R2 queue drained", 32'(exp_q.size()), 32'd0);
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule